// File: doc/BRIEF.md
# Directory Invalidation Controller

This block is the home-node directory for a small group of memory blocks shared by a fixed number of cores. It keeps no block data. For each block it records which cores hold a copy, which core owns it exclusively, and an ownership version. Cores send it read, ownership and write-back requests. It answers each request one cycle later. When an ownership change needs other copies removed, it sends one invalidate message that covers every affected core. It then withholds the grant until each of those cores has acknowledged.

All requests for a block are serialized at its entry. The entry state at the clock edge where a request is accepted decides the answer. While acknowledgements are outstanding the entry is busy, and further read or ownership requests to that block are told to retry. Every exclusive grant advances the block's version counter, which wraps. A write-back must present the version it was granted under. A write-back with an old version, or from a core that is not the owner, is dropped and produces no memory write strobe.

Top module: `dir_inval_ctrl`

## Requirements
- R1: A read request (kind 0) to a block that is idle or shared, or that the requester already owns, is answered with a shared grant (response 0) carrying the block's current version. The requester is then recorded as a holder.
- R2: An ownership request (kind 1) to a block held by cores other than the requester is answered with pending (response 2). In the same cycle an invalidate is raised whose mask has bit i set for every holder i except the requester.
- R3: A deferred grant is raised only once every invalidated core has acknowledged. Acknowledgements from cores outside the outstanding set, and repeated acknowledgements, are ignored.
- R4: A deferred ownership grant reports the requester, the block and the new version, with the exclusive flag set. Afterwards the requester is the sole holder of the block.
- R5: An ownership request that finds no holder other than the requester is answered at once with an exclusive grant (response 1), and no invalidate is sent.
- R6: Each exclusive grant of a block raises its version by one, modulo 2^VERW. Versions start at 0 after reset.
- R7: A write-back (kind 2) is accepted only if the block is exclusive, the sender is the owner and the version matches. Acceptance gives response 4 and a one-cycle memory write strobe for that block, and leaves the block idle. Any other write-back gives response 5 and no strobe.
- R8: A read or ownership request to a block that is waiting for acknowledgements is answered with retry (response 3) and leaves that block unchanged.
- R9: A read request to a block owned exclusively by another core is answered with pending and an invalidate to the owner. After the owner's acknowledgement, a deferred grant with the exclusive flag clear goes to the reader, who becomes the only holder.
- R10: After reset, no response, invalidate, deferred grant or memory strobe is valid.
- R11: Every request is answered on the response port in the cycle after it is presented, tagged with the requester and the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 ownership, 2 write-back |
| req_core | input | CW (2) | Requesting core |
| req_blk | input | BW (2) | Target block |
| req_ver | input | VERW (3) | Version carried by a write-back |
| ack_valid | input | 1 | Invalidate acknowledgement present |
| ack_core | input | CW (2) | Acknowledging core |
| ack_blk | input | BW (2) | Block being acknowledged |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_kind | output | 3 | 0 shared, 1 exclusive, 2 pending, 3 retry, 4 write-back taken, 5 write-back dropped |
| resp_core | output | CW (2) | Core the response is for |
| resp_blk | output | BW (2) | Block of the response |
| resp_ver | output | VERW (3) | Block version after the request |
| inv_valid | output | 1 | Invalidate message valid |
| inv_mask | output | NCORE (4) | Cores to invalidate |
| inv_blk | output | BW (2) | Block to invalidate |
| cmpl_valid | output | 1 | Deferred grant valid |
| cmpl_excl | output | 1 | 1 exclusive grant, 0 shared grant |
| cmpl_core | output | CW (2) | Core receiving the deferred grant |
| cmpl_blk | output | BW (2) | Block of the deferred grant |
| cmpl_ver | output | VERW (3) | Version of the deferred grant |
| mem_wr_en | output | 1 | Accepted write-back strobe |
| mem_wr_blk | output | BW (2) | Block written back |

## Verification
A wrong holder vector stays hidden until a later ownership request to that block. It then shows as a wrong invalidate mask, or as an immediate grant where pending was due, one cycle after that request. A wrong acknowledgement count shows as a deferred grant that arrives one cycle after the wrong acknowledgement, or that never arrives. Later requests to that block then keep getting retry. A version off by one shows directly in the next grant's version field. It also shows when a current write-back is dropped, or a late one raises the memory strobe, one cycle after the write-back is presented.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

    localparam int NCORE = 4;
    localparam int NBLK  = 4;
    localparam int VERW  = 3;
    localparam int CW    = $clog2(NCORE);
    localparam int BW    = $clog2(NBLK);
    localparam int AW    = $clog2(NCORE + 1);

    typedef enum logic [1:0] {
        RQ_READ = 2'd0,
        RQ_OWN  = 2'd1,
        RQ_WB   = 2'd2,
        RQ_NONE = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        RS_SHARED  = 3'd0,
        RS_EXCL    = 3'd1,
        RS_PEND    = 3'd2,
        RS_RETRY   = 3'd3,
        RS_WB_OK   = 3'd4,
        RS_WB_DROP = 3'd5
    } rsp_kind_e;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_SHR  = 2'd1,
        DS_EXC  = 2'd2,
        DS_BUSY = 2'd3
    } dstate_e;

    typedef struct packed {
        dstate_e            st;
        logic [NCORE-1:0]   holders;
        logic [CW-1:0]      owner;
        logic [VERW-1:0]    ver;
        logic [CW-1:0]      pend_core;
        logic               pend_own;
        logic [NCORE-1:0]   wait_mask;
        logic [AW-1:0]      acks_left;
    } dir_ent_t;

    function automatic logic [NCORE-1:0] core_bit(input logic [CW-1:0] c);
        logic [NCORE-1:0] m;
        m = '0;
        m[c] = 1'b1;
        return m;
    endfunction

    function automatic logic [AW-1:0] ones(input logic [NCORE-1:0] m);
        logic [AW-1:0] n;
        n = '0;
        for (int i = 0; i < NCORE; i++) n = n + AW'(m[i]);
        return n;
    endfunction

endpackage

// File: rtl/dirctl_entry.sv
module dirctl_entry
    import dirctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd_en,
    input  dir_ent_t        upd,
    input  logic            ack_hit,
    input  logic [CW-1:0]   ack_core,
    output dir_ent_t        ent,
    output logic            done
);

    logic take;

    // an acknowledgement counts only once and only from an invalidated core
    assign take = ack_hit && (ent.st == DS_BUSY) && ent.wait_mask[ack_core];
    assign done = take && (ent.acks_left == AW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (upd_en) begin
            ent <= upd;
        end else if (take) begin
            ent.wait_mask[ack_core] <= 1'b0;
            ent.acks_left           <= ent.acks_left - AW'(1);
            if (done) begin
                ent.holders <= core_bit(ent.pend_core);
                if (ent.pend_own) begin
                    ent.st    <= DS_EXC;
                    ent.owner <= ent.pend_core;
                    ent.ver   <= ent.ver + VERW'(1);
                end else begin
                    ent.st    <= DS_SHR;
                end
            end
        end
    end

    // R3: outstanding count always equals the set of cores still to answer
    p_ack_count_r3: assert property (@(posedge clk) disable iff (rst)
        (ent.st == DS_BUSY) |-> (ent.acks_left == ones(ent.wait_mask) && ent.acks_left != '0));

    // R4: an exclusive block has exactly one holder, its owner
    p_excl_sole_r4: assert property (@(posedge clk) disable iff (rst)
        (ent.st == DS_EXC) |-> ($countones(ent.holders) == 1 && ent.holders[ent.owner]));

    // R6: version only ever advances by one
    p_ver_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ent.ver != $past(ent.ver)) |-> (ent.ver == $past(ent.ver) + VERW'(1)));

endmodule

// File: rtl/dirctl_decide.sv
module dirctl_decide
    import dirctl_pkg::*;
(
    input  req_kind_e           rq,
    input  logic [CW-1:0]       core,
    input  logic [VERW-1:0]     ver,
    input  dir_ent_t            ent,
    output logic                upd_en,
    output dir_ent_t            upd,
    output rsp_kind_e           kind,
    output logic [VERW-1:0]     rver,
    output logic [NCORE-1:0]    inv,
    output logic                mem_wr
);

    logic [NCORE-1:0] me;
    logic [NCORE-1:0] others;
    logic             busy;

    assign me     = core_bit(core);
    assign others = ent.holders & ~me;
    assign busy   = (ent.st == DS_BUSY);

    always_comb begin
        upd_en = 1'b0;
        upd    = ent;
        kind   = RS_RETRY;
        rver   = ent.ver;
        inv    = '0;
        mem_wr = 1'b0;
        unique case (rq)
            RQ_READ: begin
                if (busy) begin
                    kind = RS_RETRY;
                end else if (ent.st == DS_EXC && ent.owner != core) begin
                    upd_en         = 1'b1;
                    upd.st         = DS_BUSY;
                    upd.wait_mask  = core_bit(ent.owner);
                    upd.acks_left  = AW'(1);
                    upd.pend_core  = core;
                    upd.pend_own   = 1'b0;
                    inv            = core_bit(ent.owner);
                    kind           = RS_PEND;
                end else if (ent.st == DS_EXC) begin
                    kind = RS_SHARED;
                end else begin
                    upd_en      = 1'b1;
                    upd.st      = DS_SHR;
                    upd.holders = ent.holders | me;
                    kind        = RS_SHARED;
                end
            end
            RQ_OWN: begin
                if (busy) begin
                    kind = RS_RETRY;
                end else if (others == '0) begin
                    upd_en      = 1'b1;
                    upd.st      = DS_EXC;
                    upd.holders = me;
                    upd.owner   = core;
                    upd.ver     = ent.ver + VERW'(1);
                    rver        = ent.ver + VERW'(1);
                    kind        = RS_EXCL;
                end else begin
                    upd_en         = 1'b1;
                    upd.st         = DS_BUSY;
                    upd.wait_mask  = others;
                    upd.acks_left  = ones(others);
                    upd.pend_core  = core;
                    upd.pend_own   = 1'b1;
                    inv            = others;
                    kind           = RS_PEND;
                end
            end
            RQ_WB: begin
                if (ent.st == DS_EXC && ent.owner == core && ent.ver == ver) begin
                    upd_en      = 1'b1;
                    upd.st      = DS_IDLE;
                    upd.holders = '0;
                    mem_wr      = 1'b1;
                    kind        = RS_WB_OK;
                end else begin
                    kind = RS_WB_DROP;
                end
            end
            default: begin
                kind = RS_RETRY;
            end
        endcase
    end

endmodule

// File: rtl/dir_inval_ctrl.sv
module dir_inval_ctrl
    import dirctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [CW-1:0]       req_core,
    input  logic [BW-1:0]       req_blk,
    input  logic [VERW-1:0]     req_ver,
    input  logic                ack_valid,
    input  logic [CW-1:0]       ack_core,
    input  logic [BW-1:0]       ack_blk,
    output logic                resp_valid,
    output logic [2:0]          resp_kind,
    output logic [CW-1:0]       resp_core,
    output logic [BW-1:0]       resp_blk,
    output logic [VERW-1:0]     resp_ver,
    output logic                inv_valid,
    output logic [NCORE-1:0]    inv_mask,
    output logic [BW-1:0]       inv_blk,
    output logic                cmpl_valid,
    output logic                cmpl_excl,
    output logic [CW-1:0]       cmpl_core,
    output logic [BW-1:0]       cmpl_blk,
    output logic [VERW-1:0]     cmpl_ver,
    output logic                mem_wr_en,
    output logic [BW-1:0]       mem_wr_blk
);

    dir_ent_t           ents [NBLK];
    logic [NBLK-1:0]    done;
    logic               d_upd_en;
    dir_ent_t           d_upd;
    rsp_kind_e          d_kind;
    logic [VERW-1:0]    d_rver;
    logic [NCORE-1:0]   d_inv;
    logic               d_mem_wr;
    logic [BW-1:0]      done_idx;
    dir_ent_t           done_ent;

    dirctl_decide u_decide (
        .rq     (req_kind_e'(req_kind)),
        .core   (req_core),
        .ver    (req_ver),
        .ent    (ents[req_blk]),
        .upd_en (d_upd_en),
        .upd    (d_upd),
        .kind   (d_kind),
        .rver   (d_rver),
        .inv    (d_inv),
        .mem_wr (d_mem_wr)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        dirctl_entry u_entry (
            .clk      (clk),
            .rst      (rst),
            .upd_en   (req_valid && d_upd_en && (req_blk == BW'(b))),
            .upd      (d_upd),
            .ack_hit  (ack_valid && (ack_blk == BW'(b))),
            .ack_core (ack_core),
            .ent      (ents[b]),
            .done     (done[b])
        );
    end

    // one acknowledgement per cycle, so at most one entry completes
    always_comb begin
        done_idx = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (done[i]) done_idx = BW'(i);
        end
    end
    assign done_ent = ents[done_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_kind  <= '0;
            resp_core  <= '0;
            resp_blk   <= '0;
            resp_ver   <= '0;
            inv_valid  <= 1'b0;
            inv_mask   <= '0;
            inv_blk    <= '0;
            cmpl_valid <= 1'b0;
            cmpl_excl  <= 1'b0;
            cmpl_core  <= '0;
            cmpl_blk   <= '0;
            cmpl_ver   <= '0;
            mem_wr_en  <= 1'b0;
            mem_wr_blk <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_kind  <= d_kind;
            resp_core  <= req_core;
            resp_blk   <= req_blk;
            resp_ver   <= d_rver;
            inv_valid  <= req_valid && (d_inv != '0);
            inv_mask   <= d_inv;
            inv_blk    <= req_blk;
            mem_wr_en  <= req_valid && d_mem_wr;
            mem_wr_blk <= req_blk;
            cmpl_valid <= |done;
            cmpl_excl  <= done_ent.pend_own;
            cmpl_core  <= done_ent.pend_core;
            cmpl_blk   <= done_idx;
            cmpl_ver   <= done_ent.pend_own ? done_ent.ver + VERW'(1) : done_ent.ver;
        end
    end

    // R2: the requester is never told to invalidate its own copy
    p_inv_skips_req_r2: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !inv_mask[resp_core]);

    // R2: an invalidate always accompanies a pending answer for the same block
    p_inv_with_pend_r2: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (resp_valid && resp_kind == 3'(RS_PEND) && inv_blk == resp_blk));

    // R7: memory is written only for an accepted write-back
    p_mem_wr_ok_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (resp_valid && resp_kind == 3'(RS_WB_OK) && mem_wr_blk == resp_blk));

    // R11: every request is answered in the following cycle
    p_resp_follows_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

endmodule

// File: tb/dir_inval_ctrl_bench.sv
`timescale 1ns/1ps
module dir_inval_ctrl_bench;
    import dirctl_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic [1:0]          req_kind = '0;
    logic [CW-1:0]       req_core = '0;
    logic [BW-1:0]       req_blk = '0;
    logic [VERW-1:0]     req_ver = '0;
    logic                ack_valid = 1'b0;
    logic [CW-1:0]       ack_core = '0;
    logic [BW-1:0]       ack_blk = '0;
    logic                resp_valid;
    logic [2:0]          resp_kind;
    logic [CW-1:0]       resp_core;
    logic [BW-1:0]       resp_blk;
    logic [VERW-1:0]     resp_ver;
    logic                inv_valid;
    logic [NCORE-1:0]    inv_mask;
    logic [BW-1:0]       inv_blk;
    logic                cmpl_valid;
    logic                cmpl_excl;
    logic [CW-1:0]       cmpl_core;
    logic [BW-1:0]       cmpl_blk;
    logic [VERW-1:0]     cmpl_ver;
    logic                mem_wr_en;
    logic [BW-1:0]       mem_wr_blk;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dir_inval_ctrl u_dir_inval_ctrl (.*);

    // vector: kind, core, blk, ver, expected response, expected version
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd0, 3'd0, 3'd0, 3'd0},  // R1 read idle
        {2'd0, 2'd1, 2'd0, 3'd0, 3'd0, 3'd0},  // R1 read shared
        {2'd1, 2'd2, 2'd1, 3'd0, 3'd1, 3'd1},  // R5 own idle
        {2'd2, 2'd2, 2'd1, 3'd0, 3'd5, 3'd1},  // R7 stale version
        {2'd2, 2'd2, 2'd1, 3'd1, 3'd4, 3'd1},  // R7 good write-back
        {2'd1, 2'd3, 2'd1, 3'd0, 3'd1, 3'd2},  // R6 second grant
        {2'd2, 2'd1, 2'd1, 3'd2, 3'd5, 3'd2},  // R7 not owner
        {2'd0, 2'd3, 2'd1, 3'd0, 3'd0, 3'd2},  // R1 owner reads
        {2'd1, 2'd3, 2'd1, 3'd0, 3'd1, 3'd3},  // R5 owner re-requests
        {2'd1, 2'd0, 2'd0, 3'd0, 3'd2, 3'd0}   // R2 own with sharer
    };

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_req(input int k, input int c, input int b, input int v);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(k);
        req_core  = CW'(c);
        req_blk   = BW'(b);
        req_ver   = VERW'(v);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic do_ack(input int c, input int b);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_core  = CW'(c);
        ack_blk   = BW'(b);
        @(posedge clk);
        #1;
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R10 reset state
        check("R10 resp_valid", int'(resp_valid), 0);
        check("R10 inv_valid", int'(inv_valid), 0);
        check("R10 cmpl_valid", int'(cmpl_valid), 0);
        check("R10 mem_wr_en", int'(mem_wr_en), 0);

        for (int i = 0; i < NV; i++) begin
            do_req(int'(VEC[i][14:13]), int'(VEC[i][12:11]), int'(VEC[i][10:9]), int'(VEC[i][8:6]));
            check($sformatf("R11 vec%0d valid", i), int'(resp_valid), 1);
            check($sformatf("R11 vec%0d core", i), int'(resp_core), int'(VEC[i][12:11]));
            check($sformatf("R1/R5/R7 vec%0d kind", i), int'(resp_kind), int'(VEC[i][5:3]));
            check($sformatf("R6 vec%0d ver", i), int'(resp_ver), int'(VEC[i][2:0]));
            check($sformatf("R7 vec%0d strobe", i), int'(mem_wr_en), (VEC[i][5:3] == 3'd4) ? 1 : 0);
        end
        // last vector: R2 invalidate to core 1 only
        check("R2 inv_valid", int'(inv_valid), 1);
        check("R2 inv_mask", int'(inv_mask), 4'b0010);
        check("R2 inv_blk", int'(inv_blk), 0);

        // R8 busy block retries
        do_req(0, 2, 0, 0);
        check("R8 retry", int'(resp_kind), 3);
        check("R8 no inv", int'(inv_valid), 0);
        // R3 ack from a core that was not invalidated is ignored
        do_ack(3, 0);
        check("R3 foreign ack", int'(cmpl_valid), 0);
        do_ack(1, 0);
        check("R3 grant after ack", int'(cmpl_valid), 1);
        check("R4 excl", int'(cmpl_excl), 1);
        check("R4 core", int'(cmpl_core), 0);
        check("R4 blk", int'(cmpl_blk), 0);
        check("R4 ver", int'(cmpl_ver), 1);
        // R4 core 0 is now sole holder; R8 retried read left nothing behind
        do_req(1, 2, 0, 0);
        check("R4 pend", int'(resp_kind), 2);
        check("R4 sole mask", int'(inv_mask), 4'b0001);
        do_ack(0, 0);
        check("R4 second grant", int'(cmpl_valid), 1);
        check("R6 second ver", int'(cmpl_ver), 2);
        // R7 late write-back from the previous owner after a newer grant
        do_req(2, 0, 0, 1);
        check("R7 late wb", int'(resp_kind), 5);
        check("R7 late no strobe", int'(mem_wr_en), 0);
        do_req(2, 2, 0, 2);
        check("R7 current wb", int'(resp_kind), 4);
        check("R7 strobe", int'(mem_wr_en), 1);
        check("R7 strobe blk", int'(mem_wr_blk), 0);

        // R3 three sharers, duplicate ack does not finish early
        do_req(0, 0, 2, 0);
        do_req(0, 1, 2, 0);
        do_req(0, 2, 2, 0);
        do_req(1, 3, 2, 0);
        check("R2 three mask", int'(inv_mask), 4'b0111);
        do_ack(1, 2);
        check("R3 first ack", int'(cmpl_valid), 0);
        do_ack(1, 2);
        check("R3 duplicate ack", int'(cmpl_valid), 0);
        do_ack(0, 2);
        check("R3 second ack", int'(cmpl_valid), 0);
        do_ack(2, 2);
        check("R3 last ack", int'(cmpl_valid), 1);
        check("R4 core3", int'(cmpl_core), 3);
        check("R4 ver blk2", int'(cmpl_ver), 1);

        // R9 read recall from owner 3 of block 1 (version 3)
        do_req(0, 0, 1, 0);
        check("R9 pend", int'(resp_kind), 2);
        check("R9 mask", int'(inv_mask), 4'b1000);
        do_ack(3, 1);
        check("R9 cmpl", int'(cmpl_valid), 1);
        check("R9 shared", int'(cmpl_excl), 0);
        check("R9 core", int'(cmpl_core), 0);
        check("R9 ver", int'(cmpl_ver), 3);
        do_req(1, 0, 1, 0);
        check("R5 only holder", int'(resp_kind), 1);
        check("R5 no inv", int'(inv_valid), 0);
        check("R6 ver4", int'(resp_ver), 4);

        // R6 wrap on block 3
        for (int i = 0; i < 8; i++) begin
            do_req(1, 1, 3, 0);
            check($sformatf("R6 wrap %0d", i), int'(resp_ver), (i + 1) % 8);
        end
        do_req(2, 1, 3, 0);
        check("R6 wrapped wb", int'(resp_kind), 4);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule